// File: doc/BRIEF.md
# Bus Traffic Performance Counter

This block watches one bus port and counts data beats together with elapsed clock cycles, so that software can work out bandwidth and utilisation from a pair of readings. Each cycle it samples two strobes, one for a read data beat and one for a write data beat. Four event counters each pick, through their own select register, whether they count read beats, write beats or both. A free-running cycle counter sets a sticky wrap flag when it rolls over. The last event counter is wider than the bus word, so it is read back in two pieces.

Software drives the block through a small register port. Writes are synchronous and reads are combinational. A control word starts and stops counting and requests clears. A counter-enable word gates each counter on its own. A control state machine has three states. ST_IDLE means counting is stopped and values are held. ST_RUN means counting is live. ST_CLEAR lasts one cycle and applies any requested clears.

The transitions are named as follows. GO moves from ST_IDLE to ST_RUN on a control write with the enable bit set and no clear bit. HALT moves from ST_RUN to ST_IDLE on a control write with the enable bit clear and no clear bit. ERASE moves from any state to ST_CLEAR on a control write with either clear bit set. RESUME moves from ST_CLEAR to ST_RUN when the enable bit is latched. PARK moves from ST_CLEAR to ST_IDLE when it is not. A control write always takes precedence over the automatic exit from ST_CLEAR.

Top module: `perfmon_unit`

## Requirements
- R1: After reset every readable register returns 0: control, counter enable, flag, the cycle counter and all event counters.
- R2: Control offset 0x000, bit 0 is the enable. While it is clear, counting is stopped, and strobes applied in that state leave every counter value unchanged.
- R3: Flag offset 0x050, bit 31 becomes 1 when the cycle counter wraps from all ones to zero. It stays 1 until a cycle clear is applied.
- R4: Counter-enable offset 0x010. Bits 0 to 3 gate event counters 0 to 3, and bit 31 gates the cycle counter. A gated-off counter stays at its value while the block runs.
- R5: Event select code 0x05 counts read beats and 0x06 counts write beats. Code 0x07 counts both, adding 2 in a cycle where both strobes are high.
- R6: An event counter whose select holds any other code, including 0, never increments.
- R7: Event counter 3 is 40 bits wide. Offset 0x140 returns bits 39..8 and offset 0x150 returns bits 7..0 in its low byte, so the full value is (word at 0x140 << 8) | word at 0x150.
- R8: Control bit 1 clears the cycle counter and the wrap flag, and control bit 2 clears the event counters. After the write, the state machine spends exactly one cycle in ST_CLEAR. In that cycle the control word reads back the requested clear bits, no counting happens, and the clears take effect. Afterwards the bits read 0 and counters not selected for clearing keep their values.
- R9: The cycle counter reads at 0x100 and event counter n (n < 3) reads at 0x110 + 0x10·n. Event select n is written and read back in bits 7..0 at 0x1000 + 0x100·n, and counter enable reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_beat | input | 1 | A read data beat is transferred this cycle |
| wr_beat | input | 1 | A write data beat is transferred this cycle |
| reg_wr | input | 1 | Register write strobe, sampled on the clock edge |
| reg_addr | input | 16 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |

## Verification
A read beat and a write beat can fall in the same cycle. The bench provokes this by running stimulus vectors in which both strobe patterns are high together, sometimes on every cycle and sometimes on interleaved cycles. A counter set to the combined code must then have gained two for each such cycle, and this is judged against counts the bench builds from the patterns. The second collision is a control write landing while a clear is in progress. That case is judged by reading back the control word and counter values in the cycle after the write.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_CLEAR = 2'd2
    } pm_state_e;

    localparam logic [7:0] CODE_RD   = 8'h05;
    localparam logic [7:0] CODE_WR   = 8'h06;
    localparam logic [7:0] CODE_BOTH = 8'h07;

    localparam int OFF_CTRL    = 'h000;
    localparam int OFF_CNTEN   = 'h010;
    localparam int OFF_FLAG    = 'h050;
    localparam int OFF_CYC     = 'h100;
    localparam int OFF_EVT0    = 'h110;
    localparam int EVT_STRIDE  = 'h10;
    localparam int OFF_SEL0    = 'h1000;
    localparam int SEL_STRIDE  = 'h100;
    localparam int SPLIT_SHIFT = 8;

endpackage

// File: rtl/perfmon_ctrl_fsm.sv
module perfmon_ctrl_fsm
    import perfmon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_wr,
    input  logic [2:0] ctrl_wdata,
    output logic      cnt_run,
    output logic      clr_cyc,
    output logic      clr_evt,
    output logic [2:0] ctrl_view
);

    pm_state_e state_q, state_d;
    logic      en_q;
    logic      pend_cyc_q;
    logic      pend_evt_q;

    // next-state selection; a control write overrides every state
    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            if (|ctrl_wdata[2:1])
                state_d = ST_CLEAR;          // ERASE
            else if (ctrl_wdata[0])
                state_d = ST_RUN;            // GO
            else
                state_d = ST_IDLE;           // HALT
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_RUN:   state_d = ST_RUN;
                ST_CLEAR: state_d = en_q ? ST_RUN : ST_IDLE;  // RESUME / PARK
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register and latched control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            en_q       <= 1'b0;
            pend_cyc_q <= 1'b0;
            pend_evt_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ctrl_wr) begin
                en_q       <= ctrl_wdata[0];
                pend_cyc_q <= ctrl_wdata[1];
                pend_evt_q <= ctrl_wdata[2];
            end else if (state_q == ST_CLEAR) begin
                pend_cyc_q <= 1'b0;
                pend_evt_q <= 1'b0;
            end
        end
    end

    // outputs decoded from the current state
    always_comb begin
        cnt_run = 1'b0;
        clr_cyc = 1'b0;
        clr_evt = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_RUN:   cnt_run = 1'b1;
            ST_CLEAR: begin
                clr_cyc = pend_cyc_q;
                clr_evt = pend_evt_q;
            end
            default:  ;
        endcase
    end

    assign ctrl_view = {clr_evt, clr_cyc, en_q};

endmodule

// File: rtl/perfmon_evt_counter.sv
module perfmon_evt_counter
    import perfmon_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         enable,
    input  logic         clear,
    input  logic [7:0]   sel,
    input  logic         rd_beat,
    input  logic         wr_beat,
    output logic [W-1:0] cnt
);

    logic [1:0] step;

    always_comb begin
        unique case (sel)
            CODE_RD:   step = {1'b0, rd_beat};
            CODE_WR:   step = {1'b0, wr_beat};
            CODE_BOTH: step = {1'b0, rd_beat} + {1'b0, wr_beat};
            default:   step = 2'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (run && enable)
            cnt <= cnt + W'(step);
    end

endmodule

// File: rtl/perfmon_cyc_counter.sv
module perfmon_cyc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         enable,
    input  logic         clear,
    output logic [W-1:0] cnt,
    output logic         wrapped
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            wrapped <= 1'b0;
        end else if (clear) begin
            cnt     <= '0;
            wrapped <= 1'b0;
        end else if (run && enable) begin
            cnt <= cnt + W'(1);
            if (&cnt)
                wrapped <= 1'b1;
        end
    end

endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
    import perfmon_pkg::*;
#(
    parameter int ADDR_BITS = 16,
    parameter int NUM_EVT   = 4,
    parameter int EVT_BITS  = 32,
    parameter int WIDE_BITS = 40,
    parameter int CYC_BITS  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_beat,
    input  logic                 wr_beat,
    input  logic                 reg_wr,
    input  logic [ADDR_BITS-1:0] reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata
);

    localparam int LAST    = NUM_EVT - 1;
    localparam int LOW_TAIL = OFF_EVT0 + NUM_EVT * EVT_STRIDE;

    logic                 ctrl_wr;
    logic                 cnten_wr;
    logic                 cnt_run;
    logic                 clr_cyc;
    logic                 clr_evt;
    logic [2:0]           ctrl_view;
    logic [NUM_EVT:0]     cnten_q;
    logic [7:0]           evt_sel [NUM_EVT];
    logic [WIDE_BITS-1:0] evt_value [NUM_EVT];
    logic [CYC_BITS-1:0]  cyc_value;
    logic                 ovf_flag;
    logic                 unused_wbits;

    // observation points for the bound checker
    logic [WIDE_BITS-1:0] mon_cnt_head;
    logic [WIDE_BITS-1:0] mon_cnt_tail;
    logic [7:0]           mon_sel_head;

    assign ctrl_wr      = reg_wr && (reg_addr == ADDR_BITS'(OFF_CTRL));
    assign cnten_wr     = reg_wr && (reg_addr == ADDR_BITS'(OFF_CNTEN));
    assign unused_wbits = ^reg_wdata[30:8];

    perfmon_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (reg_wdata[2:0]),
        .cnt_run    (cnt_run),
        .clr_cyc    (clr_cyc),
        .clr_evt    (clr_evt),
        .ctrl_view  (ctrl_view)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnten_q <= '0;
        else if (cnten_wr)
            cnten_q <= {reg_wdata[31], reg_wdata[NUM_EVT-1:0]};
    end

    perfmon_cyc_counter #(.W(CYC_BITS)) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cnt_run),
        .enable  (cnten_q[NUM_EVT]),
        .clear   (clr_cyc),
        .cnt     (cyc_value),
        .wrapped (ovf_flag)
    );

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        localparam int CW = (i == LAST) ? WIDE_BITS : EVT_BITS;
        logic [CW-1:0] cnt_w;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                evt_sel[i] <= 8'h00;
            else if (reg_wr && reg_addr == ADDR_BITS'(OFF_SEL0 + i * SEL_STRIDE))
                evt_sel[i] <= reg_wdata[7:0];
        end

        perfmon_evt_counter #(.W(CW)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (cnt_run),
            .enable  (cnten_q[i]),
            .clear   (clr_evt),
            .sel     (evt_sel[i]),
            .rd_beat (rd_beat),
            .wr_beat (wr_beat),
            .cnt     (cnt_w)
        );

        assign evt_value[i] = WIDE_BITS'(cnt_w);
    end

    assign mon_cnt_head = evt_value[0];
    assign mon_cnt_tail = evt_value[LAST];
    assign mon_sel_head = evt_sel[0];

    // combinational read decode
    always_comb begin
        reg_rdata = 32'h0;
        if (reg_addr == ADDR_BITS'(OFF_CTRL))
            reg_rdata = {29'h0, ctrl_view};
        if (reg_addr == ADDR_BITS'(OFF_CNTEN)) begin
            reg_rdata[31]          = cnten_q[NUM_EVT];
            reg_rdata[NUM_EVT-1:0] = cnten_q[NUM_EVT-1:0];
        end
        if (reg_addr == ADDR_BITS'(OFF_FLAG))
            reg_rdata[31] = ovf_flag;
        if (reg_addr == ADDR_BITS'(OFF_CYC))
            reg_rdata = 32'(cyc_value);
        for (int i = 0; i < NUM_EVT; i++) begin
            if (reg_addr == ADDR_BITS'(OFF_EVT0 + i * EVT_STRIDE))
                reg_rdata = (i == LAST) ? 32'(evt_value[i] >> SPLIT_SHIFT)
                                        : 32'(evt_value[i]);
            if (reg_addr == ADDR_BITS'(OFF_SEL0 + i * SEL_STRIDE))
                reg_rdata = {24'h0, evt_sel[i]};
        end
        if (reg_addr == ADDR_BITS'(LOW_TAIL))
            reg_rdata = 32'(evt_value[LAST][SPLIT_SHIFT-1:0]);
    end

endmodule

// File: rtl/perfmon_unit_chk.sv
module perfmon_unit_chk #(
    parameter int CYC_BITS  = 32,
    parameter int WIDE_BITS = 40
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ctrl_wr,
    input logic                 cnt_run,
    input logic                 clr_cyc,
    input logic                 clr_evt,
    input logic                 ovf_flag,
    input logic [CYC_BITS-1:0]  cyc_value,
    input logic [WIDE_BITS-1:0] mon_cnt_head,
    input logic [WIDE_BITS-1:0] mon_cnt_tail,
    input logic [7:0]           mon_sel_head
);

    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !clr_cyc |=> ovf_flag);

    assert_flag_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(cyc_value) == {CYC_BITS{1'b1}}));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_run && !clr_cyc |=> $stable(cyc_value));

    assert_unconfigured_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_sel_head == 8'h00) && !clr_evt |=> $stable(mon_cnt_head));

    assert_step_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_evt |=> ((mon_cnt_tail - $past(mon_cnt_tail)) <= WIDE_BITS'(2)));

    assert_clear_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt && !ctrl_wr |=> !clr_evt);

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_evt |=> (mon_cnt_head == '0) && (mon_cnt_tail == '0));

endmodule

bind perfmon_unit perfmon_unit_chk #(
    .CYC_BITS  (CYC_BITS),
    .WIDE_BITS (WIDE_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_wr      (ctrl_wr),
    .cnt_run      (cnt_run),
    .clr_cyc      (clr_cyc),
    .clr_evt      (clr_evt),
    .ovf_flag     (ovf_flag),
    .cyc_value    (cyc_value),
    .mon_cnt_head (mon_cnt_head),
    .mon_cnt_tail (mon_cnt_tail),
    .mon_sel_head (mon_sel_head)
);

// File: tb/perfmon_unit_test.sv
module perfmon_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_beat = 1'b0;
    logic        wr_beat = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = 16'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    perfmon_unit #(.CYC_BITS(8)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_beat   (rd_beat),
        .wr_beat   (wr_beat),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // n, read pattern, write pattern, selects 0..3
    localparam logic [43:0] VECS [5] = '{
        {8'd10, 2'd1, 2'd0, 8'h05, 8'h06, 8'h00, 8'h07},
        {8'd12, 2'd0, 2'd1, 8'h05, 8'h06, 8'h00, 8'h07},
        {8'd20, 2'd1, 2'd1, 8'h07, 8'h05, 8'h06, 8'h07},
        {8'd15, 2'd2, 2'd3, 8'h05, 8'h06, 8'h07, 8'h03},
        {8'd9,  2'd3, 2'd2, 8'h00, 8'h07, 8'h06, 8'h05}
    };

    function automatic bit pat(input logic [1:0] m, input int i);
        case (m)
            2'd1:    return 1'b1;
            2'd2:    return (i % 2) == 0;
            2'd3:    return (i % 3) == 0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = 16'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        reg_addr = 16'(a);
        #1 v = reg_rdata;
    endtask

    task automatic rd_wide(output longint v);
        logic [31:0] hi, lo;
        rd('h140, hi);
        rd('h150, lo);
        v = (longint'(hi) << 8) | longint'(lo);
    endtask

    task automatic beats(input int n, input logic [1:0] rm, input logic [1:0] wm);
        for (int i = 0; i < n; i++) begin
            rd_beat = pat(rm, i);
            wr_beat = pat(wm, i);
            @(negedge clk);
        end
        rd_beat = 1'b0;
        wr_beat = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        longint      w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd('h000, v); check("R1 ctrl", v, 0);
        rd('h010, v); check("R1 cnten", v, 0);
        rd('h050, v); check("R1 flag", v, 0);
        rd('h100, v); check("R1 cycle", v, 0);
        rd('h110, v); check("R1 evt0", v, 0);
        rd_wide(w);   check("R1 evt3", w, 0);

        // R9 enable and select readback
        wr('h010, 32'h8000_000F);
        rd('h010, v); check("R9 cnten readback", v, 32'h8000_000F);
        wr('h1200, 32'h0000_00A6);
        rd('h1200, v); check("R9 select2 readback", v, 32'hA6);

        // R8 clear bits read back for exactly one cycle
        wr('h000, 32'h6);
        rd('h000, v); check("R8 clear bits visible", v, 6);
        @(negedge clk);
        rd('h000, v); check("R8 clear bits self-clear", v, 0);

        // vector table: R5, R6, R9
        foreach (VECS[k]) begin
            int          n;
            logic [1:0]  rm, wm;
            logic [7:0]  s [4];
            longint      exp_c [4];
            int          nr, nw, nb;
            n = int'(VECS[k][43:36]);
            rm = VECS[k][35:34];
            wm = VECS[k][33:32];
            for (int c = 0; c < 4; c++) s[c] = VECS[k][31 - 8*c -: 8];
            nr = 0; nw = 0;
            for (int i = 0; i < n; i++) begin
                nr += int'(pat(rm, i));
                nw += int'(pat(wm, i));
            end
            nb = nr + nw;
            for (int c = 0; c < 4; c++) begin
                wr('h1000 + 'h100 * c, {24'h0, s[c]});
                exp_c[c] = (s[c] == 8'h05) ? nr : (s[c] == 8'h06) ? nw :
                           (s[c] == 8'h07) ? nb : 0;
            end
            wr('h000, 32'h6);
            wr('h000, 32'h1);
            beats(n, rm, wm);
            wr('h000, 32'h0);
            rd('h110, v); check($sformatf("R5 vec%0d evt0", k), v, exp_c[0]);
            rd('h120, v); check($sformatf("R6 vec%0d evt1", k), v, exp_c[1]);
            rd('h130, v); check($sformatf("R5 vec%0d evt2", k), v, exp_c[2]);
            rd_wide(w);   check($sformatf("R7 vec%0d evt3", k), w, exp_c[3]);
            rd('h100, v); check($sformatf("R9 vec%0d cycle", k), v, n + 1);
        end

        // R2 counting stops and values hold while disabled
        wr('h1000, 32'h05);
        wr('h000, 32'h6);
        wr('h000, 32'h1);
        beats(5, 2'd1, 2'd0);
        wr('h000, 32'h0);
        beats(7, 2'd1, 2'd1);
        rd('h110, v); check("R2 evt0 held", v, 5);
        rd('h100, v); check("R2 cycle held", v, 6);

        // R4 per-counter enable gating
        for (int c = 0; c < 4; c++) wr('h1000 + 'h100 * c, 32'h07);
        wr('h010, 32'h0000_0001);
        wr('h000, 32'h6);
        wr('h000, 32'h1);
        beats(6, 2'd1, 2'd1);
        wr('h000, 32'h0);
        rd('h110, v); check("R4 evt0 enabled", v, 12);
        rd('h120, v); check("R4 evt1 gated", v, 0);
        rd_wide(w);   check("R4 evt3 gated", w, 0);
        rd('h100, v); check("R4 cycle gated", v, 0);
        wr('h010, 32'h8000_000F);

        // R8 selective clears
        wr('h000, 32'h6);
        wr('h000, 32'h1);
        beats(4, 2'd1, 2'd0);
        wr('h000, 32'h4);
        @(negedge clk);
        rd('h110, v); check("R8 evt cleared", v, 0);
        rd('h100, v); check("R8 cycle kept", v, 5);
        wr('h000, 32'h2);
        @(negedge clk);
        rd('h100, v); check("R8 cycle cleared", v, 0);

        // R3 wrap flag and R7 split read of the wide counter
        wr('h1300, 32'h05);
        wr('h000, 32'h6);
        wr('h000, 32'h1);
        beats(300, 2'd1, 2'd0);
        wr('h000, 32'h0);
        rd('h050, v); check("R3 wrap flag set", v, 32'h8000_0000);
        rd('h100, v); check("R3 cycle wrapped", v, 301 % 256);
        rd('h140, v); check("R7 upper word", v, 1);
        rd('h150, v); check("R7 lower byte", v, 44);
        wr('h000, 32'h0);
        rd('h050, v); check("R3 flag sticky", v, 32'h8000_0000);
        wr('h000, 32'h2);
        @(negedge clk);
        rd('h050, v); check("R3 flag cleared", v, 0);
        rd_wide(w);   check("R8 evt3 kept", w, 300);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule